// File: doc/BRIEF.md
# Load/Store Multiple Address Sequencer

The sequencer turns one block-transfer command into a stream of single-word memory requests. A command gives a base address, a 16-bit register list, and its controls: the direction (ascending or descending), pre- or post-indexing, load or store, the privileged bank-select bit and write-back enable. It accepts the command in one cycle. It then presents one request at a time: the register index, the word address, the transfer direction and a user-bank flag. A request advances only when the memory side accepts it with a valid/ready handshake.

Registers go out in ascending index order at ascending addresses, whatever the direction. A descending transfer therefore starts its address from the population count of the list. After the last request the block pulses a completion cycle. That cycle carries the final base value for write-back, a pipeline-flush flag and a status-restore flag, which the register file and the pipeline control use.

Top module: `ldm_addr_seq`

## Requirements
- R1: Every set bit of `reg_list_i` produces exactly one accepted request, so the number of requests equals the population count of the list.
- R2: Requests go out in strictly ascending register index. Each accepted request is followed by an address 4 bytes higher.
- R3: The first address depends on the direction and indexing. Ascending post-indexed starts at base. Ascending pre-indexed starts at base+4. Descending post-indexed starts at base-4*(n-1). Descending pre-indexed starts at base-4*n. All arithmetic wraps modulo 2^32.
- R4: While `req_valid_o` is high and `req_ready_i` is low, the register index and address hold steady.
- R5: `done_o` pulses for exactly one cycle, in the cycle after the last accepted request. In that cycle `wb_valid_o` equals the write-back enable. `wb_addr_o` is base+4*n for an ascending transfer and base-4*n for a descending one.
- R6: `flush_o` is high in the completion cycle exactly when the command is a load and bit 15 of the list is set. It is low at all other times.
- R7: `req_user_o` is high on every request of a command whose bank-select bit is set, provided bit 15 is clear or the command is a store. It is low otherwise.
- R8: `psr_restore_o` is high in the completion cycle exactly when the bank-select bit is set, the command is a load, and bit 15 is set.
- R9: An empty list issues no request. `done_o` then rises in the cycle after the command is taken, and the write-back value equals base.
- R10: `start_i` is ignored while the block is busy, and the running sequence continues unchanged.
- R11: After reset the block is idle: `busy_o`, `req_valid_o`, `done_o`, `flush_o` and `psr_restore_o` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Command strobe, taken only when idle |
| base_i | input | 32 | Base address |
| reg_list_i | input | 16 | Register list, bit k selects register k |
| up_i | input | 1 | 1 = ascending, 0 = descending |
| pre_i | input | 1 | 1 = pre-indexed, 0 = post-indexed |
| load_i | input | 1 | 1 = load, 0 = store |
| bank_sel_i | input | 1 | Privileged bank-select bit |
| wb_en_i | input | 1 | Write-back enable |
| busy_o | output | 1 | Command in progress |
| req_valid_o | output | 1 | Request valid |
| req_ready_i | input | 1 | Request accepted by memory side |
| req_reg_o | output | 4 | Register index of request |
| req_addr_o | output | 32 | Word address of request |
| req_load_o | output | 1 | Request is a load |
| req_user_o | output | 1 | Request targets user-mode bank |
| done_o | output | 1 | One-cycle completion pulse |
| wb_valid_o | output | 1 | Write-back value is to be committed |
| wb_addr_o | output | 32 | Write-back base value |
| flush_o | output | 1 | Pipeline flush required |
| psr_restore_o | output | 1 | Copy saved status into current status |

## Verification
The first request appears one cycle after the command edge. Every later request appears one cycle after the edge that accepted the one before it. The completion pulse, with its write-back, flush and restore values, comes one cycle after the final acceptance, or one cycle after the command when the list is empty. The bench drives inputs on the falling edge. At each falling edge it compares the outputs with a behavioural queue of expected requests, and it pops the queue only when it drove ready for the edge in between. Random and constant ready patterns exercise the hold behaviour.

// File: rtl/ldm_seq_pkg.sv
package ldm_seq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } seq_state_e;
endpackage

// File: rtl/ldm_popcnt.sv
module ldm_popcnt #(
  parameter int unsigned W     = 16,
  localparam int unsigned CW   = $clog2(W + 1)
) (
  input  logic [W-1:0]  vec_i,
  output logic [CW-1:0] cnt_o
);
  always_comb begin
    cnt_o = '0;
    for (int i = 0; i < W; i++) cnt_o = cnt_o + CW'(vec_i[i]);
  end
endmodule

// File: rtl/ldm_low_idx.sv
module ldm_low_idx #(
  parameter int unsigned W   = 16,
  localparam int unsigned IW = $clog2(W)
) (
  input  logic [W-1:0]  vec_i,
  output logic [IW-1:0] idx_o
);
  always_comb begin
    idx_o = '0;
    for (int i = W - 1; i >= 0; i--)
      if (vec_i[i]) idx_o = IW'(i);
  end
endmodule

// File: rtl/ldm_addr_calc.sv
module ldm_addr_calc #(
  parameter int unsigned AW     = 32,
  parameter int unsigned CW     = 5,
  parameter int unsigned STRIDE = 4
) (
  input  logic [AW-1:0] base_i,
  input  logic [CW-1:0] cnt_i,
  input  logic          up_i,
  input  logic          pre_i,
  output logic [AW-1:0] first_o,
  output logic [AW-1:0] wb_o
);
  localparam logic [AW-1:0] STEP = AW'(STRIDE);
  logic [AW-1:0] span;

  assign span = AW'(cnt_i) * STEP;

  always_comb begin
    if (up_i) begin
      first_o = pre_i ? base_i + STEP : base_i;
      wb_o    = base_i + span;
    end else begin
      // lowest register sits at lowest address
      first_o = pre_i ? base_i - span : base_i - span + STEP;
      wb_o    = base_i - span;
    end
  end
endmodule

// File: rtl/ldm_addr_seq.sv
module ldm_addr_seq #(
  parameter int unsigned AW     = 32,
  parameter int unsigned NREG   = 16,
  parameter int unsigned STRIDE = 4,
  localparam int unsigned IW    = $clog2(NREG),
  localparam int unsigned CW    = $clog2(NREG + 1)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic [AW-1:0]   base_i,
  input  logic [NREG-1:0] reg_list_i,
  input  logic            up_i,
  input  logic            pre_i,
  input  logic            load_i,
  input  logic            bank_sel_i,
  input  logic            wb_en_i,
  output logic            busy_o,
  output logic            req_valid_o,
  input  logic            req_ready_i,
  output logic [IW-1:0]   req_reg_o,
  output logic [AW-1:0]   req_addr_o,
  output logic            req_load_o,
  output logic            req_user_o,
  output logic            done_o,
  output logic            wb_valid_o,
  output logic [AW-1:0]   wb_addr_o,
  output logic            flush_o,
  output logic            psr_restore_o
);
  import ldm_seq_pkg::*;

  localparam int unsigned PC_IDX = NREG - 1;

  seq_state_e      state_q;
  logic [NREG-1:0] mask_q;
  logic [AW-1:0]   addr_q, wb_q;
  logic            load_q, user_q, wb_en_q, flush_q, restore_q;

  logic [CW-1:0]   cnt;
  logic [AW-1:0]   first_addr, wb_addr;
  logic [NREG-1:0] mask_next;
  logic            take, fire;

  ldm_popcnt #(.W(NREG)) u_cnt (.vec_i(reg_list_i), .cnt_o(cnt));

  ldm_addr_calc #(.AW(AW), .CW(CW), .STRIDE(STRIDE)) u_calc (
    .base_i (base_i),
    .cnt_i  (cnt),
    .up_i   (up_i),
    .pre_i  (pre_i),
    .first_o(first_addr),
    .wb_o   (wb_addr)
  );

  ldm_low_idx #(.W(NREG)) u_low (.vec_i(mask_q), .idx_o(req_reg_o));

  assign take      = start_i && (state_q == ST_IDLE);
  assign fire      = req_valid_o && req_ready_i;
  assign mask_next = mask_q & (mask_q - NREG'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      mask_q    <= '0;
      addr_q    <= '0;
      wb_q      <= '0;
      load_q    <= 1'b0;
      user_q    <= 1'b0;
      wb_en_q   <= 1'b0;
      flush_q   <= 1'b0;
      restore_q <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (take) begin
          mask_q    <= reg_list_i;
          addr_q    <= first_addr;
          wb_q      <= (reg_list_i == '0) ? base_i : wb_addr;
          load_q    <= load_i;
          user_q    <= bank_sel_i && (!reg_list_i[PC_IDX] || !load_i);
          wb_en_q   <= wb_en_i;
          flush_q   <= load_i && reg_list_i[PC_IDX];
          restore_q <= bank_sel_i && load_i && reg_list_i[PC_IDX];
          state_q   <= (reg_list_i == '0) ? ST_DONE : ST_RUN;
        end
        ST_RUN: if (fire) begin
          mask_q <= mask_next;
          addr_q <= addr_q + AW'(STRIDE);
          if (mask_next == '0) state_q <= ST_DONE;
        end
        ST_DONE: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o        = (state_q != ST_IDLE);
  assign req_valid_o   = (state_q == ST_RUN);
  assign req_addr_o    = addr_q;
  assign req_load_o    = load_q;
  assign req_user_o    = req_valid_o && user_q;
  assign done_o        = (state_q == ST_DONE);
  assign wb_valid_o    = done_o && wb_en_q;
  assign wb_addr_o     = wb_q;
  assign flush_o       = done_o && flush_q;
  assign psr_restore_o = done_o && restore_q;
endmodule

// File: rtl/ldm_addr_seq_chk.sv
module ldm_addr_seq_chk #(
  parameter int unsigned AW     = 32,
  parameter int unsigned IW     = 4,
  parameter int unsigned STRIDE = 4
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          busy_o,
  input logic          req_valid_o,
  input logic          req_ready_i,
  input logic [IW-1:0] req_reg_o,
  input logic [AW-1:0] req_addr_o,
  input logic          done_o,
  input logic          wb_valid_o,
  input logic          flush_o,
  input logic          psr_restore_o
);
  a_r4_hold_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o && !req_ready_i |=> req_valid_o && $stable(req_addr_o) && $stable(req_reg_o));

  a_r2_addr_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o && $past(req_valid_o && req_ready_i)
      |-> req_addr_o == $past(req_addr_o) + AW'(STRIDE) && req_reg_o > $past(req_reg_o));

  a_r9_no_req_in_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_valid_o && done_o));

  a_r5_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o && !busy_o);

  a_r5_wb_in_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_valid_o |-> done_o);

  a_r6_flush_in_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_o |-> done_o);

  a_r8_restore_implies_flush: assert property (@(posedge clk_i) disable iff (!rst_ni)
    psr_restore_o |-> flush_o);

  a_r10_busy_until_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && !done_o |=> busy_o);
endmodule

bind ldm_addr_seq ldm_addr_seq_chk #(.AW(AW), .IW(IW), .STRIDE(STRIDE)) chk_i (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .busy_o       (busy_o),
  .req_valid_o  (req_valid_o),
  .req_ready_i  (req_ready_i),
  .req_reg_o    (req_reg_o),
  .req_addr_o   (req_addr_o),
  .done_o       (done_o),
  .wb_valid_o   (wb_valid_o),
  .flush_o      (flush_o),
  .psr_restore_o(psr_restore_o)
);

// File: tb/ldm_addr_seq_tb_top.sv
module ldm_addr_seq_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [31:0] base_i = '0;
  logic [15:0] reg_list_i = '0;
  logic        up_i = 1'b0, pre_i = 1'b0, load_i = 1'b0, bank_sel_i = 1'b0, wb_en_i = 1'b0;
  logic        req_ready_i = 1'b0;
  logic        busy_o, req_valid_o, req_load_o, req_user_o, done_o, wb_valid_o, flush_o, psr_restore_o;
  logic [3:0]  req_reg_o;
  logic [31:0] req_addr_o, wb_addr_o;

  int checks = 0;
  int failures = 0;
  int cycles = 0;

  always #10 clk_i = ~clk_i;

  ldm_addr_seq dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .base_i(base_i),
    .reg_list_i(reg_list_i), .up_i(up_i), .pre_i(pre_i), .load_i(load_i),
    .bank_sel_i(bank_sel_i), .wb_en_i(wb_en_i), .busy_o(busy_o),
    .req_valid_o(req_valid_o), .req_ready_i(req_ready_i), .req_reg_o(req_reg_o),
    .req_addr_o(req_addr_o), .req_load_o(req_load_o), .req_user_o(req_user_o),
    .done_o(done_o), .wb_valid_o(wb_valid_o), .wb_addr_o(wb_addr_o),
    .flush_o(flush_o), .psr_restore_o(psr_restore_o)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  always @(posedge clk_i) begin
    cycles++;
    if (cycles > 100000) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=done", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  // rdy_mode: 0 random, 1 always ready
  task automatic run_op(input logic [31:0] b, input logic [15:0] l, input bit u, input bit p,
                        input bit ld, input bit s, input bit wb, input int rdy_mode, input bit poke);
    int          regs[$];
    logic [31:0] addrs[$];
    int          n;
    logic [31:0] lo, wbexp;
    bit          uexp, fexp, rexp;
    int          iter;
    n = $countones(l);
    lo = u ? (p ? b + 32'd4 : b) : (p ? b - 32'(4 * n) : b - 32'(4 * n) + 32'd4);
    wbexp = u ? b + 32'(4 * n) : b - 32'(4 * n);
    uexp = s && (!l[15] || !ld);
    fexp = ld && l[15];
    rexp = s && ld && l[15];
    for (int k = 0; k < 16; k++)
      if (l[k]) begin regs.push_back(k); addrs.push_back(lo); lo = lo + 32'd4; end

    start_i = 1'b1; base_i = b; reg_list_i = l; up_i = u; pre_i = p;
    load_i = ld; bank_sel_i = s; wb_en_i = wb; req_ready_i = 1'b0;
    @(negedge clk_i);
    start_i = 1'b0;
    iter = 0;
    while (regs.size() > 0) begin
      bit rdy;
      chk(req_valid_o === 1'b1, "R1 valid", 32'(req_valid_o), 1);
      chk(req_reg_o === 4'(regs[0]), "R2 reg order", 32'(req_reg_o), 32'(regs[0]));
      chk(req_addr_o === addrs[0], "R3 address", req_addr_o, addrs[0]);
      chk(req_load_o === ld, "R1 dir", 32'(req_load_o), 32'(ld));
      chk(req_user_o === uexp, "R7 user bank", 32'(req_user_o), 32'(uexp));
      chk(done_o === 1'b0 && flush_o === 1'b0, "R6 early done/flush", 32'({done_o, flush_o}), 0);
      // R10: foreign start mid-run
      if (poke && iter == 1) begin
        start_i = 1'b1; base_i = 32'hDEAD_0000; reg_list_i = 16'h0001; up_i = ~u;
      end else begin
        start_i = 1'b0;
      end
      rdy = (rdy_mode == 1) ? 1'b1 : 1'($urandom % 2);
      req_ready_i = rdy;
      @(negedge clk_i);
      if (rdy) begin void'(regs.pop_front()); void'(addrs.pop_front()); end
      iter++;
    end
    start_i = 1'b0;
    req_ready_i = 1'b0;
    chk(req_valid_o === 1'b0, "R1 no extra request", 32'(req_valid_o), 0);
    chk(done_o === 1'b1, "R5 done", 32'(done_o), 1);
    chk(wb_valid_o === wb, "R5 wb_valid", 32'(wb_valid_o), 32'(wb));
    chk(wb_addr_o === wbexp, "R5 wb_addr", wb_addr_o, wbexp);
    chk(flush_o === fexp, "R6 flush", 32'(flush_o), 32'(fexp));
    chk(psr_restore_o === rexp, "R8 restore", 32'(psr_restore_o), 32'(rexp));
    @(negedge clk_i);
    chk(done_o === 1'b0 && busy_o === 1'b0, "R5 one-cycle done", 32'({done_o, busy_o}), 0);
    chk(flush_o === 1'b0 && psr_restore_o === 1'b0, "R6 R8 flags drop", 32'({flush_o, psr_restore_o}), 0);
  endtask

  initial begin
    #1;
    chk(busy_o === 1'b0 && req_valid_o === 1'b0 && done_o === 1'b0, "R11 reset idle",
        32'({busy_o, req_valid_o, done_o}), 0);
    @(negedge clk_i); @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(busy_o === 1'b0 && flush_o === 1'b0 && psr_restore_o === 1'b0, "R11 idle after reset",
        32'({busy_o, flush_o, psr_restore_o}), 0);

    run_op(32'h0000_1000, 16'h00A5, 1, 0, 1, 0, 1, 0, 0);  // R3 up post
    run_op(32'h0000_1000, 16'h00A5, 1, 1, 0, 0, 1, 0, 0);  // R3 up pre
    run_op(32'h0000_2000, 16'h0F0F, 0, 0, 1, 0, 1, 0, 0);  // R3 down post
    run_op(32'h0000_2000, 16'h0F0F, 0, 1, 0, 0, 0, 0, 0);  // R3 down pre, no wb
    run_op(32'h0000_3000, 16'h0000, 1, 0, 1, 0, 1, 0, 0);  // R9 empty
    run_op(32'h0000_3000, 16'h0000, 0, 1, 1, 1, 1, 1, 0);  // R9 empty descending
    run_op(32'h0000_4000, 16'h8000, 1, 0, 1, 1, 1, 1, 0);  // R6 R8 single r15 load S
    run_op(32'h0000_4000, 16'h8003, 1, 1, 0, 1, 1, 0, 0);  // R7 store with r15, S
    run_op(32'h0000_4000, 16'h0006, 0, 0, 1, 1, 0, 0, 0);  // R7 load without r15, S
    run_op(32'h0000_4000, 16'h8010, 0, 1, 1, 0, 1, 0, 0);  // R6 load r15 no S
    run_op(32'h0000_0008, 16'hFFFF, 0, 1, 1, 0, 1, 1, 0);  // R3 wrap, full list
    run_op(32'hFFFF_FFF8, 16'hFFFF, 1, 1, 0, 0, 1, 0, 0);  // R3 wrap up
    run_op(32'h0000_5000, 16'h1248, 1, 0, 1, 0, 1, 0, 1);  // R10 start while busy
    run_op(32'h0000_6000, 16'h1248, 0, 0, 0, 0, 1, 1, 1);  // R10 always ready
    for (int t = 0; t < 20; t++)
      run_op($urandom, 16'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
             1'($urandom), 1'($urandom), t % 2, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule